// File: doc/BRIEF.md
# Flash Sector Guard with Identifier Readout

This unit sits beside the command controller of a two-bank flash array with fourteen sectors. It keeps one lock bit per sector and decides, for every program or erase request the controller forwards, whether the addressed sector may be touched. A request that lands on a locked sector is refused with a one-cycle `reject` pulse, and the controller drops it. A request that is allowed comes back as a one-cycle `grant` pulse together with the decoded sector index. The same unit answers identifier reads: manufacturer code, device code (which depends on the boot orientation) and the lock status of a sector.

Sector decoding uses word-address bits 17 to 12, so the space is split into 64 units of 4 Kwords. Six uniform 32-Kword sectors form the large bank. Two 16-Kword, two 8-Kword and four 4-Kword sectors form the small boot/parameter bank. The `boot_top` input places the small bank at the top or the bottom of the space. Sectors are numbered 0 to 13 in ascending address order. A level input `hv_unlock` stands for the high-voltage-on-reset condition. While it is held, locked sectors accept program and erase. The lock bits themselves are never changed by it, so protection returns as soon as it drops.

Control is a single state machine. The states are ST_IDLE (accepting), ST_EVAL (decision), ST_GRANT, ST_REJECT and ST_REPLY. The transitions are: ST_IDLE to ST_EVAL when `req_valid` or `as_rd` is high; ST_EVAL to ST_REPLY for an identifier read, to ST_REJECT when the request is refused, and to ST_GRANT otherwise; ST_GRANT, ST_REJECT and ST_REPLY each return to ST_IDLE after one cycle.

Top module: `sector_guard_unit`

## Requirements
- R1: After reset all fourteen lock bits are clear, `ready` is 1, and `grant`, `reject`, `as_valid` are 0 with `as_data` 0.
- R2: A request (`req_op` 0 = program, 1 = erase) sampled while `ready` is 1 is handled as follows. If the target sector is unlocked, `grant` is high for exactly the one cycle after the second rising edge, with `grant_sector` set to the sector index. `ready` is 0 from the first edge until the third edge.
- R3: A program or erase request to a locked sector gives a one-cycle `reject` in place of `grant`. `grant` and `reject` are never high together.
- R4: A lock request (`req_op` 2) sets the bit of the addressed sector only, and answers with `grant`.
- R5: An unlock-all request (`req_op` 3) is granted, and clears every bit, only when all fourteen sectors are locked. Otherwise it answers with `reject` and leaves all bits unchanged.
- R6: While `hv_unlock` is 1 during the decision cycle, program and erase to locked sectors are granted. The lock bits are unchanged, so the same request is rejected once `hv_unlock` is 0.
- R7: With `boot_top` = 0, 4K units (addr[17:12]) 0-3 map to sectors 0-3 (4 Kwords each), units 4-7 to sectors 4-5 (8K), units 8-15 to sectors 6-7 (16K), and units 16-63 to sectors 8-13 (32K).
- R8: With `boot_top` = 1, units 0-47 map to sectors 0-5 (32K), units 48-55 to sectors 6-7 (16K), units 56-59 to sectors 8-9 (8K), and units 60-63 to sectors 10-13 (4K).
- R9: An identifier read (`as_rd`) gives `as_valid` for one cycle, at the same cycle as R2's `grant`. With addr[6], addr[1] and addr[0] all 0 the data is 0x0001 (manufacturer).
- R10: With addr[6]=0, addr[1]=0 and addr[0]=1 the read returns the device code. The low byte is 0x0C when `boot_top` = 1 and 0x0F when `boot_top` = 0. The upper byte is 0x22 when `word_mode` = 1 and 0x00 otherwise.
- R11: With addr[6]=0, addr[1]=1 and addr[0]=0 the read returns 0x0001 if the sector selected by addr[17:12] is locked and 0x0000 if it is not. Any other combination, including addr[6]=1, returns 0x0000.
- R12: Requests arriving while `ready` is 0 are ignored. When `req_valid` and `as_rd` arrive together, the request is served and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_top | input | 1 | 1: small sectors at the top of the space |
| word_mode | input | 1 | 1: 16-bit bus, device code carries an upper byte |
| hv_unlock | input | 1 | Temporary lift of all locks while high |
| req_valid | input | 1 | Program/erase/lock/unlock request strobe |
| req_op | input | 2 | 0 program, 1 erase, 2 lock sector, 3 unlock all |
| as_rd | input | 1 | Identifier read strobe |
| addr | input | 18 | Word address |
| ready | output | 1 | Unit idle and accepting |
| grant | output | 1 | Request allowed (one-cycle pulse) |
| reject | output | 1 | Request refused (one-cycle pulse) |
| grant_sector | output | 4 | Sector index of the request being answered |
| as_valid | output | 1 | Identifier data valid (one-cycle pulse) |
| as_data | output | 16 | Identifier data |

## Verification
Each result is due in the cycle after the second rising edge that follows the sampled strobe. That edge latches the request and then registers the decision, and `ready` returns one edge later. The bench drives inputs on falling edges and holds them for a single cycle. It reads `grant`, `reject`, `as_valid` and `as_data` at the second falling edge after release, and reads `ready` at the first. Lock-bit changes can only be seen through later requests or status reads, so every check that depends on them is made after the following `ready`.

// File: rtl/sgu_pkg.sv
package sgu_pkg;
    localparam int SECTORS = 14;
    localparam int SECT_W  = 4;
    localparam int UNIT_W  = 6;
    localparam int ADDR_W  = 18;
    localparam int DATA_W  = 16;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_ERASE      = 2'd1,
        OP_LOCK       = 2'd2,
        OP_UNLOCK_ALL = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_GRANT,
        ST_REJECT,
        ST_REPLY
    } state_e;
endpackage

// File: rtl/sgu_sector_map.sv
module sgu_sector_map
    import sgu_pkg::*;
(
    input  logic [UNIT_W-1:0] unit,
    input  logic              top,
    output logic [SECT_W-1:0] sect
);
    logic [UNIT_W-1:0] s;
    logic [UNIT_W-1:0] v;

    always_comb begin
        v = unit - 6'd48;
        if (!top) begin
            if (unit < 6'd4)       s = unit;
            else if (unit < 6'd8)  s = 6'd4 + ((unit - 6'd4) >> 1);
            else if (unit < 6'd16) s = 6'd6 + ((unit - 6'd8) >> 2);
            else                   s = 6'd8 + ((unit - 6'd16) >> 3);
        end else begin
            if (unit < 6'd48)      s = unit >> 3;
            else if (v < 6'd4)     s = 6'd6;
            else if (v < 6'd8)     s = 6'd7;
            else if (v < 6'd10)    s = 6'd8;
            else if (v < 6'd12)    s = 6'd9;
            else                   s = 6'd10 + (v - 6'd12);
        end
        sect = SECT_W'(s);
    end
endmodule

// File: rtl/sgu_lock_bits.sv
module sgu_lock_bits
    import sgu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [SECT_W-1:0]  set_idx,
    input  logic               clr_all,
    output logic [SECTORS-1:0] bits
);
    for (genvar i = 0; i < SECTORS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bits[i] <= 1'b0;
            else if (clr_all)
                bits[i] <= 1'b0;
            else if (set_en && set_idx == SECT_W'(i))
                bits[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/sgu_id_codes.sv
module sgu_id_codes
    import sgu_pkg::*;
#(
    parameter logic [7:0] MFR_ID  = 8'h01,
    parameter logic [7:0] DEV_TOP = 8'h0C,
    parameter logic [7:0] DEV_BOT = 8'h0F,
    parameter logic [7:0] DEV_HI  = 8'h22
) (
    input  logic              a6,
    input  logic              a1,
    input  logic              a0,
    input  logic              word_mode,
    input  logic              top,
    input  logic              locked,
    output logic [DATA_W-1:0] code
);
    always_comb begin
        code = '0;
        if (!a6) begin
            unique case ({a1, a0})
                2'b00:   code = {8'h00, MFR_ID};
                2'b01:   code = {(word_mode ? DEV_HI : 8'h00),
                                 (top ? DEV_TOP : DEV_BOT)};
                2'b10:   code = {8'h00, 7'd0, locked};
                default: code = '0;
            endcase
        end
    end
endmodule

// File: rtl/sector_guard_unit.sv
module sector_guard_unit
    import sgu_pkg::*;
#(
    parameter logic [7:0] MFR_ID  = 8'h01,
    parameter logic [7:0] DEV_TOP = 8'h0C,
    parameter logic [7:0] DEV_BOT = 8'h0F,
    parameter logic [7:0] DEV_HI  = 8'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_top,
    input  logic              word_mode,
    input  logic              hv_unlock,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              as_rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              grant,
    output logic              reject,
    output logic [SECT_W-1:0] grant_sector,
    output logic              as_valid,
    output logic [DATA_W-1:0] as_data
);
    state_e             st_q, st_d;
    op_e                op_q;
    logic               is_read_q;
    logic [SECT_W-1:0]  sect_q;
    logic               a6_q, a1_q, a0_q;
    logic [DATA_W-1:0]  reply_q;
    logic [SECT_W-1:0]  sect_in;
    logic [SECTORS-1:0] prot_bits;
    logic [DATA_W-1:0]  id_code;
    logic               accept;
    logic               deny;
    logic               all_locked;
    logic               sel_locked;
    logic               lock_set;
    logic               lock_clr;
    logic               unused_addr_bits;

    assign unused_addr_bits = ^{addr[11:7], addr[5:2]};

    sgu_sector_map u_map (
        .unit (addr[ADDR_W-1:ADDR_W-UNIT_W]),
        .top  (boot_top),
        .sect (sect_in)
    );

    sgu_lock_bits u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (lock_set),
        .set_idx (sect_q),
        .clr_all (lock_clr),
        .bits    (prot_bits)
    );

    sgu_id_codes #(
        .MFR_ID  (MFR_ID),
        .DEV_TOP (DEV_TOP),
        .DEV_BOT (DEV_BOT),
        .DEV_HI  (DEV_HI)
    ) u_ids (
        .a6        (a6_q),
        .a1        (a1_q),
        .a0        (a0_q),
        .word_mode (word_mode),
        .top       (boot_top),
        .locked    (sel_locked),
        .code      (id_code)
    );

    assign accept     = (st_q == ST_IDLE) && (req_valid || as_rd);
    assign all_locked = &prot_bits;
    assign sel_locked = prot_bits[sect_q];

    // Decision made in ST_EVAL from latched request and live unlock flag
    always_comb begin
        unique case (op_q)
            OP_PROG, OP_ERASE: deny = sel_locked && !hv_unlock;
            OP_LOCK:           deny = 1'b0;
            OP_UNLOCK_ALL:     deny = !all_locked;
            default:           deny = 1'b1;
        endcase
    end

    assign lock_set = (st_q == ST_EVAL) && !is_read_q && (op_q == OP_LOCK);
    assign lock_clr = (st_q == ST_EVAL) && !is_read_q &&
                      (op_q == OP_UNLOCK_ALL) && all_locked;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid || as_rd) st_d = ST_EVAL;
            ST_EVAL: begin
                if (is_read_q)  st_d = ST_REPLY;
                else if (deny)  st_d = ST_REJECT;
                else            st_d = ST_GRANT;
            end
            ST_GRANT:  st_d = ST_IDLE;
            ST_REJECT: st_d = ST_IDLE;
            ST_REPLY:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Request capture and reply register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_PROG;
            is_read_q <= 1'b0;
            sect_q    <= '0;
            a6_q      <= 1'b0;
            a1_q      <= 1'b0;
            a0_q      <= 1'b0;
            reply_q   <= '0;
        end else begin
            if (accept) begin
                op_q      <= op_e'(req_op);
                is_read_q <= !req_valid;
                sect_q    <= sect_in;
                a6_q      <= addr[6];
                a1_q      <= addr[1];
                a0_q      <= addr[0];
            end
            if (st_q == ST_EVAL && is_read_q)
                reply_q <= id_code;
        end
    end

    // Outputs
    always_comb begin
        ready        = 1'b0;
        grant        = 1'b0;
        reject       = 1'b0;
        as_valid     = 1'b0;
        as_data      = '0;
        grant_sector = sect_q;
        unique case (st_q)
            ST_IDLE:   ready = 1'b1;
            ST_EVAL:   ;
            ST_GRANT:  grant = 1'b1;
            ST_REJECT: reject = 1'b1;
            ST_REPLY: begin
                as_valid = 1'b1;
                as_data  = reply_q;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/sgu_checker.sv
module sgu_checker
    import sgu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               grant,
    input logic               reject,
    input logic               as_valid,
    input logic               req_valid,
    input logic               as_rd,
    input logic [SECTORS-1:0] prot_bits
);
    localparam logic [SECTORS-1:0] ALL_SET = '1;

    p_single_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, reject, as_valid}));

    p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && (req_valid || as_rd)) |=> !ready);

    p_quiet_when_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !(grant || reject || as_valid));

    p_grant_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (ready && !grant));

    p_reply_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        as_valid |=> !as_valid);

    p_clear_from_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(prot_bits) & ~prot_bits) != '0) |->
            (prot_bits == '0 && $past(prot_bits) == ALL_SET));

    p_one_lock_at_a_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(prot_bits & ~$past(prot_bits)) <= 1);
endmodule

bind sector_guard_unit sgu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .grant     (grant),
    .reject    (reject),
    .as_valid  (as_valid),
    .req_valid (req_valid),
    .as_rd     (as_rd),
    .prot_bits (prot_bits)
);

// File: tb/sector_guard_unit_test.sv
module sector_guard_unit_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boot_top, word_mode, hv_unlock;
    logic        req_valid, as_rd;
    logic [1:0]  req_op;
    logic [17:0] addr;
    logic        ready, grant, reject, as_valid;
    logic [3:0]  grant_sector;
    logic [15:0] as_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic        o_g, o_r, o_v;
    logic [3:0]  o_s;
    logic [15:0] o_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_guard_unit uut (
        .clk(clk), .rst_n(rst_n), .boot_top(boot_top), .word_mode(word_mode),
        .hv_unlock(hv_unlock), .req_valid(req_valid), .req_op(req_op),
        .as_rd(as_rd), .addr(addr), .ready(ready), .grant(grant),
        .reject(reject), .grant_sector(grant_sector), .as_valid(as_valid),
        .as_data(as_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Independent model of the sector map from the stated sizes
    function automatic int sz_of(int k, bit top);
        if (top) return (k < 6) ? 8 : (k < 8) ? 4 : (k < 10) ? 2 : 1;
        else     return (k < 4) ? 1 : (k < 6) ? 2 : (k < 8) ? 4 : 8;
    endfunction

    function automatic int exp_sect(int unit, bit top);
        int base = 0;
        for (int k = 0; k < 14; k++) begin
            if (unit < base + sz_of(k, top)) return k;
            base += sz_of(k, top);
        end
        return -1;
    endfunction

    function automatic int base_of(int k, bit top);
        int base = 0;
        for (int j = 0; j < k; j++) base += sz_of(j, top);
        return base;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 0; as_rd = 0; req_op = 0; addr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one strobe; sample results at the second falling edge after release
    task automatic issue(input logic [1:0] op, input logic rq, input logic rd,
                         input logic [17:0] a);
        @(negedge clk);
        req_valid = rq; as_rd = rd; req_op = op; addr = a;
        @(negedge clk);
        req_valid = 0; as_rd = 0;
        @(negedge clk);
        o_g = grant; o_r = reject; o_v = as_valid; o_s = grant_sector; o_d = as_data;
        @(negedge clk);
    endtask

    function automatic logic [17:0] ua(int unit, logic [11:0] low);
        return {unit[5:0], low};
    endfunction

    task automatic status(input int unit, output logic [15:0] d);
        issue(2'd0, 1'b0, 1'b1, ua(unit, 12'h002));
        d = o_d;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        chk("R1 ready", ready, 1);
        chk("R1 outputs", {grant, reject, as_valid}, 0);
        chk("R1 as_data", as_data, 0);
        status(0, d);
        chk("R1 sector0 unlocked", d, 16'h0000);
    endtask

    task automatic t_prog_erase();
        @(negedge clk);
        req_valid = 1; req_op = 2'd0; addr = ua(9, 12'h123);
        @(negedge clk);
        req_valid = 0;
        chk("R2 ready low after accept", ready, 0);
        @(negedge clk);
        chk("R2 grant", {grant, reject}, 2'b10);
        chk("R2 sector", grant_sector, 6);
        @(negedge clk);
        chk("R2 ready back", ready, 1);
        chk("R2 grant one cycle", grant, 0);
        issue(2'd1, 1, 0, ua(20, 12'h000));
        chk("R2 erase grant", {o_g, o_r}, 2'b10);
        chk("R2 erase sector", o_s, 8);
    endtask

    task automatic t_lock_and_block();
        logic [15:0] d;
        issue(2'd2, 1, 0, ua(3, 12'h0F0));
        chk("R4 lock granted", {o_g, o_r}, 2'b10);
        issue(2'd0, 1, 0, ua(3, 12'h000));
        chk("R3 program locked rejected", {o_g, o_r}, 2'b01);
        issue(2'd1, 1, 0, ua(3, 12'h000));
        chk("R3 erase locked rejected", {o_g, o_r}, 2'b01);
        issue(2'd0, 1, 0, ua(4, 12'h000));
        chk("R4 neighbour still writable", {o_g, o_r}, 2'b10);
        status(2, d);
        chk("R4 neighbour status", d, 16'h0000);
        status(3, d);
        chk("R11 locked status", d, 16'h0001);
    endtask

    task automatic t_hv();
        logic [15:0] d;
        hv_unlock = 1;
        issue(2'd0, 1, 0, ua(3, 12'h000));
        chk("R6 program under unlock", {o_g, o_r}, 2'b10);
        issue(2'd1, 1, 0, ua(3, 12'h000));
        chk("R6 erase under unlock", {o_g, o_r}, 2'b10);
        hv_unlock = 0;
        issue(2'd0, 1, 0, ua(3, 12'h000));
        chk("R6 relocked after drop", {o_g, o_r}, 2'b01);
        status(3, d);
        chk("R6 bit kept", d, 16'h0001);
    endtask

    task automatic t_unlock_all();
        logic [15:0] d;
        issue(2'd3, 1, 0, ua(0, 12'h000));
        chk("R5 refused when partial", {o_g, o_r}, 2'b01);
        status(3, d);
        chk("R5 bits unchanged", d, 16'h0001);
        for (int k = 0; k < 14; k++) issue(2'd2, 1, 0, ua(base_of(k, 0), 12'h000));
        status(63, d);
        chk("R4 last sector locked", d, 16'h0001);
        issue(2'd3, 1, 0, ua(0, 12'h000));
        chk("R5 granted when full", {o_g, o_r}, 2'b10);
        status(3, d);
        chk("R5 sector3 cleared", d, 16'h0000);
        status(63, d);
        chk("R5 sector13 cleared", d, 16'h0000);
        issue(2'd0, 1, 0, ua(3, 12'h000));
        chk("R5 writable after clear", {o_g, o_r}, 2'b10);
    endtask

    task automatic t_map(input bit top);
        boot_top = top;
        for (int u = 0; u < 64; u++) begin
            issue(2'd0, 1, 0, ua(u, 12'hABC));
            if (top) chk("R8 top map", {o_g, o_s}, {1'b1, 4'(exp_sect(u, 1))});
            else     chk("R7 bottom map", {o_g, o_s}, {1'b1, 4'(exp_sect(u, 0))});
        end
        boot_top = 0;
    endtask

    task automatic t_ids();
        word_mode = 1; boot_top = 0;
        issue(2'd0, 0, 1, 18'h3F000);
        chk("R9 manufacturer", {o_v, o_d}, {1'b1, 16'h0001});
        chk("R9 no grant on read", o_g, 0);
        issue(2'd0, 0, 1, 18'h00001);
        chk("R10 bottom word", o_d, 16'h220F);
        boot_top = 1;
        issue(2'd0, 0, 1, 18'h00001);
        chk("R10 top word", o_d, 16'h220C);
        word_mode = 0;
        issue(2'd0, 0, 1, 18'h00001);
        chk("R10 top byte", o_d, 16'h000C);
        boot_top = 0; word_mode = 1;
        issue(2'd0, 0, 1, 18'h00041);
        chk("R11 a6 high", o_d, 16'h0000);
        issue(2'd0, 0, 1, 18'h00003);
        chk("R11 a1a0 both", o_d, 16'h0000);
    endtask

    task automatic t_busy_priority();
        int extra;
        @(negedge clk);
        req_valid = 1; req_op = 2'd0; addr = ua(0, 12'h000);
        @(negedge clk);
        addr = ua(63, 12'h000);
        @(negedge clk);
        req_valid = 0;
        chk("R12 first request served", {grant, grant_sector}, {1'b1, 4'd0});
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (grant || reject) extra++;
        end
        chk("R12 busy request ignored", extra, 0);
        issue(2'd0, 1, 1, ua(5, 12'h000));
        chk("R12 request wins over read", {o_g, o_v}, 2'b10);
    endtask

    initial begin
        boot_top = 0; word_mode = 1; hv_unlock = 0;
        req_valid = 0; as_rd = 0; req_op = 0; addr = 0; rst_n = 0;
        t_reset();
        t_prog_erase();
        t_lock_and_block();
        t_hv();
        t_unlock_all();
        do_reset();
        t_map(0);
        t_map(1);
        t_ids();
        t_busy_priority();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule